// File: doc/BRIEF.md
# Seed Index Table Builder

This block fills a seed-to-position index held in an external single-port synchronous memory. Each seed owns a fixed region of memory. The region is a count word followed by up to CAP position words. For every (seed, position) pair it accepts, the block first reads the seed's count word. It then writes the count back plus one and stores the position in the next free position word. Once a seed's region is full, further positions for that seed are dropped and an overflow pulse is raised.

The seed value selects the region directly. The region stride is SLOT_WORDS = 2^ceil(log2(CAP+1)) words, so the memory address is the seed concatenated with a word index, and word index 0 is the count. Before a build starts, a clear pass can be requested. It writes zero to every seed's count word, one seed per cycle, and leaves the position words alone.

Pairs arrive on a valid/ready stream. The memory returns read data one cycle after the address is presented. The block issues the count read in the same cycle it accepts a pair, so an accepted pair occupies three cycles, or two if it overflows.

Top module: `seed_index_builder`

## Requirements
- R1: After reset, in_ready is 1, clear_busy is 0, mem_we is 0 and ovf is 0 while the inputs are idle.
- R2: in_ready is 0 in the two cycles after an accepted pair that is stored, and in the one cycle after an accepted pair that overflows. It returns to 1 in the following cycle.
- R3: In the cycle a pair is accepted (in_valid and in_ready both 1), mem_we is 0 and mem_addr is in_seed*SLOT_WORDS, which is the count word of that seed.
- R4: One cycle after acceptance, if the returned count is below CAP, the block writes count+1 to the same count word and ovf stays 0.
- R5: Two cycles after acceptance of a stored pair, the block writes the accepted position to word index count+1 of the seed's region.
- R6: If the returned count is CAP or more, ovf is 1 for exactly that cycle, nothing is written, and the seed's memory is left unchanged.
- R7: A clear_start seen while idle lowers in_ready in that same cycle. The block then raises clear_busy for 2^SEED_W cycles, writing 0 to the count word of seed 0, 1, 2 and so on in ascending order, one per cycle, with position words untouched.
- R8: clear_start is ignored while an append is in flight: clear_busy stays 0 and the append completes unchanged.
- R9: After any sequence of pairs, every seed's count word equals min(pairs sent to it, CAP). Its position words hold the first CAP positions in arrival order, and words beyond the count keep their prior contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_start | input | 1 | Request a clear pass over all count words (sampled while idle) |
| clear_busy | output | 1 | High while the clear pass runs |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_seed | input | SEED_W | Seed, selects the memory region |
| in_pos | input | DATA_W | Position to append |
| mem_addr | output | SEED_W+SLOT_LG | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| ovf | output | 1 | One-cycle pulse when a position is dropped for a full seed |

## Verification
Results fall due as follows:
- The count read address is due in the cycle of acceptance.
- The count write-back or the overflow pulse is due one cycle later.
- The position write is due two cycles later.
- in_ready returns three cycles after acceptance, or two after an overflow.
- During a clear pass, the count word of seed i is written i+1 cycles after clear_start is sampled.

The bench drives inputs on the falling edge and samples 1 ns later, stepping one falling edge per cycle so that each check lands in exactly the cycle above. Its memory model is read back at the end and compared against counts and positions computed arithmetically from the stimulus.

// File: rtl/sib_pkg.sv
// Shared types for the seed index table builder.
// Assumes: used by all sib_* modules; no parameters live here.
package sib_pkg;
    // Control states of the append engine.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHK,
        ST_WPOS,
        ST_CLR
    } sib_state_e;

    // Memory operation requested by the control for the current cycle.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_CNT,
        OP_WR_CNT,
        OP_WR_POS,
        OP_CLR
    } sib_op_e;
endpackage

// File: rtl/sib_clear_walker.sv
// Seed counter for the clear pass: steps through every seed once.
// Assumes: the number of seeds is a power of two, so the counter wraps
// back to zero by itself after the last seed and needs no reload.
module sib_clear_walker #(
    parameter int SEED_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [SEED_W-1:0] idx,
    output logic              last
);
    // Advance to the next seed on every clear cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    // Flag the final seed so the pass can end.
    always_comb begin
        last = &idx;
    end
endmodule

// File: rtl/sib_append_ctrl.sv
// Control for the counted append: count read, count write-back, position write.
// Also sequences the clear pass.
// Assumes: memory read data is valid exactly one cycle after the address,
// and nothing else writes the memory while a pair is in flight.
module sib_append_ctrl
    import sib_pkg::*;
#(
    parameter int SEED_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CAP     = 3,
    parameter int SLOT_LG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_start,
    input  logic               in_valid,
    input  logic [SEED_W-1:0]  in_seed,
    input  logic [DATA_W-1:0]  in_pos,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [SEED_W-1:0]  clr_idx,
    input  logic               clr_last,
    output logic               in_ready,
    output sib_state_e         state,
    output sib_op_e            op,
    output logic [SEED_W-1:0]  op_seed,
    output logic [SLOT_LG-1:0] op_word,
    output logic [DATA_W-1:0]  op_data,
    output logic               ovf
);
    sib_state_e         nxt_state;
    logic [SEED_W-1:0]  seed_q;
    logic [DATA_W-1:0]  pos_q;
    logic [SLOT_LG-1:0] slot_q;
    logic [DATA_W-1:0]  cnt_inc;
    logic               full;
    logic               accept;

    // Count arithmetic on the word returned by memory.
    always_comb begin
        cnt_inc = mem_rdata + DATA_W'(1);
        full    = (mem_rdata >= DATA_W'(CAP));
    end

    // Handshake: accept only when idle and no clear is being requested.
    always_comb begin
        in_ready = rst_n && (state == ST_IDLE) && !clear_start;
        accept   = in_ready && in_valid;
        ovf      = (state == ST_CHK) && full;
    end

    // Next state and the memory operation for this cycle.
    always_comb begin
        nxt_state = state;
        op        = OP_NONE;
        op_seed   = seed_q;
        op_word   = '0;
        op_data   = '0;
        unique case (state)
            ST_IDLE: begin
                if (clear_start) begin
                    nxt_state = ST_CLR;
                end else if (in_valid) begin
                    nxt_state = ST_CHK;
                    op        = OP_RD_CNT;
                    op_seed   = in_seed;
                end
            end
            ST_CHK: begin
                if (full) begin
                    nxt_state = ST_IDLE;
                end else begin
                    nxt_state = ST_WPOS;
                    op        = OP_WR_CNT;
                    op_data   = cnt_inc;
                end
            end
            ST_WPOS: begin
                nxt_state = ST_IDLE;
                op        = OP_WR_POS;
                op_word   = slot_q;
                op_data   = pos_q;
            end
            ST_CLR: begin
                op      = OP_CLR;
                op_seed = clr_idx;
                if (clr_last) begin
                    nxt_state = ST_IDLE;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register and capture of the pair and its target word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            seed_q <= '0;
            pos_q  <= '0;
            slot_q <= '0;
        end else begin
            state <= nxt_state;
            if (accept) begin
                seed_q <= in_seed;
                pos_q  <= in_pos;
            end
            if (state == ST_CHK) begin
                slot_q <= cnt_inc[SLOT_LG-1:0];
            end
        end
    end
endmodule

// File: rtl/sib_mem_port.sv
// Turns a control operation into memory port signals.
// The address is the seed concatenated with the word index inside its region.
// Assumes: the region stride is a power of two, so no multiplier is needed.
module sib_mem_port
    import sib_pkg::*;
#(
    parameter int SEED_W  = 4,
    parameter int DATA_W  = 32,
    parameter int SLOT_LG = 2
) (
    input  sib_op_e                   op,
    input  logic [SEED_W-1:0]         op_seed,
    input  logic [SLOT_LG-1:0]        op_word,
    input  logic [DATA_W-1:0]         op_data,
    output logic [SEED_W+SLOT_LG-1:0] mem_addr,
    output logic                      mem_we,
    output logic [DATA_W-1:0]         mem_wdata
);
    // Address formation and write decode.
    always_comb begin
        mem_addr  = {op_seed, op_word};
        mem_we    = (op == OP_WR_CNT) || (op == OP_WR_POS) || (op == OP_CLR);
        mem_wdata = op_data;
    end
endmodule

// File: rtl/seed_index_builder.sv
// Top of the seed index table builder: appends positions to per-seed arrays
// in an external memory, and clears all count words on request.
// Assumes: single-port synchronous memory with one-cycle read latency, and
// CAP >= 1. Region stride is 2^ceil(log2(CAP+1)) words.
module seed_index_builder
    import sib_pkg::*;
#(
    parameter int SEED_W = 4,
    parameter int DATA_W = 32,
    parameter int CAP    = 3,
    localparam int SLOT_LG = $clog2(CAP + 1),
    localparam int ADDR_W  = SEED_W + SLOT_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_start,
    output logic              clear_busy,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SEED_W-1:0] in_seed,
    input  logic [DATA_W-1:0] in_pos,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ovf
);
    sib_state_e         state;
    sib_op_e            op;
    logic [SEED_W-1:0]  op_seed;
    logic [SLOT_LG-1:0] op_word;
    logic [DATA_W-1:0]  op_data;
    logic [SEED_W-1:0]  clr_idx;
    logic               clr_last;

    // Clear pass is active exactly in the clear state.
    always_comb begin
        clear_busy = (state == ST_CLR);
    end

    sib_clear_walker #(.SEED_W(SEED_W)) walker_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (clear_busy),
        .idx   (clr_idx),
        .last  (clr_last)
    );

    sib_append_ctrl #(
        .SEED_W (SEED_W),
        .DATA_W (DATA_W),
        .CAP    (CAP),
        .SLOT_LG(SLOT_LG)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_start(clear_start),
        .in_valid   (in_valid),
        .in_seed    (in_seed),
        .in_pos     (in_pos),
        .mem_rdata  (mem_rdata),
        .clr_idx    (clr_idx),
        .clr_last   (clr_last),
        .in_ready   (in_ready),
        .state      (state),
        .op         (op),
        .op_seed    (op_seed),
        .op_word    (op_word),
        .op_data    (op_data),
        .ovf        (ovf)
    );

    sib_mem_port #(
        .SEED_W (SEED_W),
        .DATA_W (DATA_W),
        .SLOT_LG(SLOT_LG)
    ) port_i (
        .op       (op),
        .op_seed  (op_seed),
        .op_word  (op_word),
        .op_data  (op_data),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/sib_checker.sv
// Port-level properties of the seed index table builder, bound to the top.
// Assumes: the memory model returns read data one cycle after the address.
module sib_checker #(
    parameter int SEED_W = 4,
    parameter int DATA_W = 32,
    parameter int CAP    = 3,
    localparam int SLOT_LG = $clog2(CAP + 1),
    localparam int ADDR_W  = SEED_W + SLOT_LG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_start,
    input logic              clear_busy,
    input logic              in_valid,
    input logic              in_ready,
    input logic [SEED_W-1:0] in_seed,
    input logic [DATA_W-1:0] in_pos,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              ovf
);
    logic accept;
    always_comb accept = in_valid && in_ready;

    // R2: no new pair is taken in the cycle after an acceptance.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    // R3: the acceptance cycle reads the seed's count word.
    a_r3_count_read: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (!mem_we && mem_addr == {in_seed, {SLOT_LG{1'b0}}}));

    // R4: the count word of the accepted seed is written back incremented.
    a_r4_count_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(accept) && !ovf) |->
            (mem_we && mem_addr == {$past(in_seed), {SLOT_LG{1'b0}}}
             && mem_wdata == mem_rdata + DATA_W'(1)));

    // R5: the accepted position is written two cycles after acceptance.
    a_r5_position_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(accept, 2) && !$past(ovf)) |->
            (mem_we && mem_wdata == $past(in_pos, 2)
             && mem_addr[ADDR_W-1:SLOT_LG] == $past(in_seed, 2)));

    // R6: overflow only on a full count, with no write.
    a_r6_overflow_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (!mem_we && $past(accept) && mem_rdata >= DATA_W'(CAP)));

    // R6: after an overflow the block is idle again.
    a_r6_ready_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (in_ready || clear_start));

    // R7: clear cycles write zero to count words and block the input.
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_busy |-> (mem_we && mem_wdata == '0
                        && mem_addr[SLOT_LG-1:0] == '0 && !in_ready));

    // R7: clear visits seeds in ascending order.
    a_r7_clear_order: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_busy && $past(clear_busy)) |->
            (mem_addr[ADDR_W-1:SLOT_LG]
             == SEED_W'($past(mem_addr[ADDR_W-1:SLOT_LG]) + 1'b1)));

    // R8: a clear never begins in the middle of an append.
    a_r8_no_clear_midway: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !clear_busy);

    // R6: a drop and a write never coincide.
    a_r6_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf, mem_we}));
endmodule

bind seed_index_builder sib_checker #(
    .SEED_W(SEED_W),
    .DATA_W(DATA_W),
    .CAP   (CAP)
) chk_i (.*);

// File: tb/seed_index_builder_tb_top.sv
// Bench for the seed index table builder: memory model, per-cycle checks of
// each append and clear pass, and a final sweep of the memory contents.
module seed_index_builder_tb_top;
    localparam int SEED_W     = 3;
    localparam int DATA_W     = 32;
    localparam int CAP        = 3;
    localparam int SLOT_LG    = $clog2(CAP + 1);
    localparam int SLOT_WORDS = 1 << SLOT_LG;
    localparam int ADDR_W     = SEED_W + SLOT_LG;
    localparam int NSEED      = 1 << SEED_W;
    localparam int NWORD      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clear_start = 1'b0;
    logic              clear_busy;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [SEED_W-1:0] in_seed = '0;
    logic [DATA_W-1:0] in_pos = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              ovf;

    logic [DATA_W-1:0] mem [NWORD];
    int exp_cnt [NSEED];
    logic [DATA_W-1:0] exp_pos [NSEED][CAP];
    int total = 0;
    int bad = 0;
    int sent [NSEED];

    always #2 clk = ~clk;

    seed_index_builder #(.SEED_W(SEED_W), .DATA_W(DATA_W), .CAP(CAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_start(clear_start), .clear_busy(clear_busy),
        .in_valid(in_valid), .in_ready(in_ready), .in_seed(in_seed), .in_pos(in_pos),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ovf(ovf)
    );

    // Single-port synchronous memory, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [DATA_W-1:0] fill_val(input int w);
        return 32'hDEAD_0000 | DATA_W'(w);
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One pair; checks each cycle of the append. Starts and ends 1 ns after a falling edge.
    task automatic push(input int s, input logic [DATA_W-1:0] p, input bit interfere);
        int base;
        base = s * SLOT_WORDS;
        in_valid = 1'b1;
        in_seed  = SEED_W'(s);
        in_pos   = p;
        #0;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        chk("R3 read we", {31'd0, mem_we}, 0);
        chk("R3 read addr", DATA_W'(mem_addr), DATA_W'(base));
        @(negedge clk);
        in_valid = 1'b0;
        if (interfere) clear_start = 1'b1;
        #1;
        chk("R2 ready low", {31'd0, in_ready}, 0);
        if (exp_cnt[s] < CAP) begin
            chk("R4 ovf", {31'd0, ovf}, 0);
            chk("R4 we", {31'd0, mem_we}, 1);
            chk("R4 addr", DATA_W'(mem_addr), DATA_W'(base));
            chk("R4 data", mem_wdata, DATA_W'(exp_cnt[s] + 1));
            @(negedge clk);
            #1;
            clear_start = 1'b0;
            chk("R2 ready low 2", {31'd0, in_ready}, 0);
            chk("R8 no clear", {31'd0, clear_busy}, 0);
            chk("R5 we", {31'd0, mem_we}, 1);
            chk("R5 addr", DATA_W'(mem_addr), DATA_W'(base + exp_cnt[s] + 1));
            chk("R5 data", mem_wdata, p);
            exp_pos[s][exp_cnt[s]] = p;
            exp_cnt[s]++;
        end else begin
            chk("R6 ovf", {31'd0, ovf}, 1);
            chk("R6 we", {31'd0, mem_we}, 0);
        end
        clear_start = 1'b0;
        @(negedge clk);
        #1;
        chk("R2 ready back", {31'd0, in_ready}, 1);
        chk("R8 still idle", {31'd0, clear_busy}, 0);
        chk("R6 ovf low", {31'd0, ovf}, 0);
    endtask

    // Clear pass with per-cycle checks.
    task automatic do_clear();
        clear_start = 1'b1;
        #0;
        chk("R7 ready drops", {31'd0, in_ready}, 0);
        @(negedge clk);
        clear_start = 1'b0;
        #1;
        for (int i = 0; i < NSEED; i++) begin
            chk("R7 busy", {31'd0, clear_busy}, 1);
            chk("R7 we", {31'd0, mem_we}, 1);
            chk("R7 addr", DATA_W'(mem_addr), DATA_W'(i * SLOT_WORDS));
            chk("R7 data", mem_wdata, 0);
            @(negedge clk);
            #1;
        end
        chk("R7 busy end", {31'd0, clear_busy}, 0);
        chk("R7 ready end", {31'd0, in_ready}, 1);
        for (int s = 0; s < NSEED; s++) exp_cnt[s] = 0;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < NWORD; w++) mem[w] = fill_val(w);
        for (int s = 0; s < NSEED; s++) begin
            exp_cnt[s] = 0;
            sent[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 ready", {31'd0, in_ready}, 1);
        chk("R1 busy", {31'd0, clear_busy}, 0);
        chk("R1 we", {31'd0, mem_we}, 0);
        chk("R1 ovf", {31'd0, ovf}, 0);

        do_clear();
        for (int s = 0; s < NSEED; s++) begin
            chk("R7 count zero", mem[s * SLOT_WORDS], 0);
            for (int k = 1; k < SLOT_WORDS; k++)
                chk("R7 position kept", mem[s * SLOT_WORDS + k], fill_val(s * SLOT_WORDS + k));
        end

        // Round-robin sweep: seed s receives s mod (CAP+2) pairs.
        for (int r = 0; r < CAP + 2; r++) begin
            for (int s = 0; s < NSEED; s++) begin
                if (r < s % (CAP + 2)) begin
                    push(s, DATA_W'(s * 256 + r), (s == 2 && r == 0));
                    sent[s]++;
                end
            end
        end
        // Hammer one seed past its capacity back to back.
        for (int r = 0; r < CAP + 2; r++) begin
            push(NSEED - 1, DATA_W'(32'h7000 + r), 1'b0);
            sent[NSEED - 1]++;
        end

        // R9: final memory sweep against the arithmetic model.
        for (int s = 0; s < NSEED; s++) begin
            int c;
            c = (sent[s] < CAP) ? sent[s] : CAP;
            chk("R9 count", mem[s * SLOT_WORDS], DATA_W'(c));
            chk("R9 model count", DATA_W'(exp_cnt[s]), DATA_W'(c));
            for (int k = 0; k < CAP; k++) begin
                if (k < c)
                    chk("R9 position", mem[s * SLOT_WORDS + 1 + k], exp_pos[s][k]);
                else
                    chk("R9 untouched", mem[s * SLOT_WORDS + 1 + k],
                        fill_val(s * SLOT_WORDS + 1 + k));
            end
        end

        // Second clear resets counts and keeps stored positions.
        do_clear();
        for (int s = 0; s < NSEED; s++)
            chk("R7 recount zero", mem[s * SLOT_WORDS], 0);
        chk("R7 positions survive", mem[(NSEED - 1) * SLOT_WORDS + 1], exp_pos[NSEED - 1][0]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule